// File: doc/BRIEF.md
# Per-Processor Interrupt Priority Presenter

This block sits next to one processor and decides when that processor must take an interrupt. Incoming notifications each carry a priority number from 0 (most favoured) to 7 (least favoured). The block remembers which priority levels have work waiting in an 8-bit pending mask, one bit per level. It derives the most favoured waiting level from that mask and compares it with the processor's current priority threshold. When a waiting level is strictly more favoured than the threshold, it sets an exception flag and drives the interrupt line.

The processor has two ways to act on the block. It can write a new threshold at any time. It can also issue an accept read. An accept read returns the exception status together with a priority value. If an exception was flagged, the same read moves the waiting level into the threshold, consumes that level's pending bit and drops the flag. The accept data is combinational in the cycle of the accept strobe. All state changes take effect at the following clock edge.

Top module: `ipp_presenter`

## Requirements
- R1: After reset the pending mask is empty, the pending level is 0xFF, the threshold is 0xFF, the exception flag is 0 and `irq_o` is low. An accept read in this state returns 0x00FF.
- R2: A notification of priority p in 0..7 sets mask bit (7 − p), so priority 0 lands on the MSB. A notification with p above 7 changes nothing.
- R3: The pending level equals the number of leading zeros of the mask, which is the smallest pending priority number. It is 0xFF while the mask is empty.
- R4: One clock after the pending level becomes strictly less than the threshold, the exception flag (bit 7 of the status byte) is set and `irq_o` is high. An equal or larger pending level raises nothing.
- R5: A threshold write triggers the same comparison. Writing a threshold above a waiting pending level raises `irq_o` on the next cycle.
- R6: An accept read with the flag set does four things at the next edge: it copies the pending level into the threshold, clears that level's mask bit, recomputes the pending level and clears the flag.
- R7: In the accept cycle, `accept_data_o[15:8]` is the status byte as it was before the accept. `accept_data_o[7:0]` is the threshold as it will be after the accept's own update.
- R8: An accept read with the flag clear leaves the threshold, the mask and the flag unchanged, and returns 0x00 followed by the current threshold.
- R9: Repeated notifications at one priority collapse into one mask bit, and one accept consumes it.
- R10: A notification in the same cycle as an accept is merged after the accept's update. It can therefore set the flag again at once.
- R11: If a threshold write coincides with an accept that finds the flag set, the accept's threshold update wins and the written value is discarded.
- R12: Once set, the exception flag stays set until an accept read, even if the threshold is later written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| note_valid_i | input | 1 | Notification strobe |
| note_prio_i | input | 8 | Priority of the notification |
| thr_wr_i | input | 1 | Threshold write strobe |
| thr_wdata_i | input | 8 | New threshold value |
| accept_i | input | 1 | Accept read strobe |
| accept_data_o | output | 16 | Status byte (bits 15:8) and resulting threshold (bits 7:0) |
| irq_o | output | 1 | Interrupt line to the processor |

## Verification
The embedded properties check the following on every cycle:
- a more favoured pending level never coexists with a clear flag;
- an accept with the flag set copies the pending level into the threshold and clears the consumed mask bit;
- an accept without the flag changes nothing;
- the flag is sticky;
- an empty mask always reads back as level 0xFF.

Some behaviour can only be shown by the bench's scenarios, because it depends on concrete values arriving in a particular order:
- the mapping from priority to mask bit, including out-of-range priorities;
- the collapsing of duplicate notifications;
- the returned status and threshold bytes;
- the ordering when a notification or a threshold write lands in the same cycle as an accept.

// File: rtl/ipp_pkg.sv
package ipp_pkg;
  localparam int unsigned LEVELS  = 8;
  localparam int unsigned PRIO_W  = 8;
  localparam int unsigned STAT_W  = 8;
  localparam int unsigned FLAG_POS = STAT_W - 1;
  typedef logic [PRIO_W-1:0] prio_t;
  localparam prio_t PRIO_NONE = '1;
endpackage

// File: rtl/ipp_rst_sync.sv
module ipp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/ipp_lzc.sv
module ipp_lzc #(
  parameter int unsigned N      = 8,
  parameter int unsigned PRIO_W = 8
) (
  input  logic [N-1:0]      vec_i,
  output logic [PRIO_W-1:0] lvl_o
);
  // Later (higher) indices overwrite earlier ones, so the MSB wins.
  always_comb begin
    lvl_o = '1;
    for (int i = 0; i < N; i++) begin
      if (vec_i[i]) lvl_o = PRIO_W'(N - 1 - i);
    end
  end
endmodule

// File: rtl/ipp_pend_buf.sv
module ipp_pend_buf #(
  parameter int unsigned N      = 8,
  parameter int unsigned PRIO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_en_i,
  input  logic [PRIO_W-1:0] set_prio_i,
  input  logic              clr_en_i,
  input  logic [PRIO_W-1:0] clr_prio_i,
  output logic [N-1:0]      pend_q_o,
  output logic [N-1:0]      pend_d_o
);
  logic [N-1:0] set_mask;
  logic [N-1:0] clr_mask;
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;
  logic         pend_en;

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign set_mask[g] = set_en_i && (set_prio_i == PRIO_W'(N - 1 - g));
    assign clr_mask[g] = clr_en_i && (clr_prio_i == PRIO_W'(N - 1 - g));
  end

  // Clear first, then merge the new notification.
  always_comb begin
    pend_en = set_en_i | clr_en_i;
    pend_d  = (pend_q & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_q_o = pend_q;
  assign pend_d_o = pend_en ? pend_d : pend_q;

  p_set_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_mask != '0) |=> ((pend_q & $past(set_mask)) == $past(set_mask)));

  p_clear_consumes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_mask != '0 && (clr_mask & set_mask) == '0) |=> ((pend_q & $past(clr_mask)) == '0));
endmodule

// File: rtl/ipp_prio_ctl.sv
module ipp_prio_ctl #(
  parameter int unsigned PRIO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              thr_wr_i,
  input  logic [PRIO_W-1:0] thr_wdata_i,
  input  logic [PRIO_W-1:0] lvl_d_i,
  output logic [PRIO_W-1:0] lvl_q_o,
  output logic [PRIO_W-1:0] thr_q_o,
  output logic [PRIO_W-1:0] thr_d_o,
  output logic              flag_q_o,
  output logic              take_o
);
  logic [PRIO_W-1:0] lvl_q, thr_q, thr_d;
  logic              flag_q, flag_d, take, thr_en;

  always_comb begin
    take   = accept_i & flag_q;
    thr_en = take | thr_wr_i;
    thr_d  = take ? lvl_q : (thr_wr_i ? thr_wdata_i : thr_q);
    flag_d = (flag_q & ~take) | (lvl_d_i < thr_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '1;
      thr_q  <= '1;
      flag_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_d_i;
      flag_q <= flag_d;
      if (thr_en) thr_q <= thr_d;
    end
  end

  assign lvl_q_o  = lvl_q;
  assign thr_q_o  = thr_q;
  assign thr_d_o  = thr_d;
  assign flag_q_o = flag_q;
  assign take_o   = take;

  p_fav_raises_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q < thr_q) |-> flag_q);

  p_take_copies_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (thr_q == $past(lvl_q)));

  p_idle_accept_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !flag_q && !thr_wr_i) |=> (thr_q == $past(thr_q)));

  p_flag_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !accept_i) |=> flag_q);
endmodule

// File: rtl/ipp_presenter.sv
module ipp_presenter
  import ipp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              note_valid_i,
  input  logic [PRIO_W-1:0] note_prio_i,
  input  logic              thr_wr_i,
  input  logic [PRIO_W-1:0] thr_wdata_i,
  input  logic              accept_i,
  output logic [STAT_W+PRIO_W-1:0] accept_data_o,
  output logic              irq_o
);
  logic              rst_n;
  logic [LEVELS-1:0] pend_q, pend_d;
  logic [PRIO_W-1:0] lvl_d, lvl_q, thr_q, thr_d;
  logic              flag_q, take;
  logic [STAT_W-1:0] status;

  ipp_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_n)
  );

  ipp_pend_buf #(.N(LEVELS), .PRIO_W(PRIO_W)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_n),
    .set_en_i(note_valid_i), .set_prio_i(note_prio_i),
    .clr_en_i(take), .clr_prio_i(lvl_q),
    .pend_q_o(pend_q), .pend_d_o(pend_d)
  );

  ipp_lzc #(.N(LEVELS), .PRIO_W(PRIO_W)) u_lzc (
    .vec_i(pend_d), .lvl_o(lvl_d)
  );

  ipp_prio_ctl #(.PRIO_W(PRIO_W)) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_n),
    .accept_i(accept_i), .thr_wr_i(thr_wr_i), .thr_wdata_i(thr_wdata_i),
    .lvl_d_i(lvl_d), .lvl_q_o(lvl_q), .thr_q_o(thr_q), .thr_d_o(thr_d),
    .flag_q_o(flag_q), .take_o(take)
  );

  always_comb begin
    status           = '0;
    status[FLAG_POS] = flag_q;
    accept_data_o    = {status, take ? lvl_q : thr_q};
  end

  assign irq_o = flag_q;

  p_empty_none_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (pend_q == '0) |-> (lvl_q == PRIO_NONE));

  p_accept_drops_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (take && !note_valid_i) |=> !irq_o);
endmodule

// File: tb/tb_ipp_presenter.sv
module tb_ipp_presenter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        nv, cw, ar;
  logic [7:0]  np, cd;
  logic [15:0] adata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] m_pend, m_thr;
  logic       m_flag;

  always #10 clk = ~clk;

  ipp_presenter dut (
    .clk_i(clk), .rst_ni(rst_n), .note_valid_i(nv), .note_prio_i(np),
    .thr_wr_i(cw), .thr_wdata_i(cd), .accept_i(ar),
    .accept_data_o(adata), .irq_o(irq)
  );

  function automatic logic [7:0] lead(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) if (v[i]) return 8'(7 - i);
    return 8'hFF;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; nv = 0; np = 0; cw = 0; cd = 0; ar = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_pend = 8'h00; m_thr = 8'hFF; m_flag = 1'b0;
  endtask

  // One cycle: drive, check outputs, advance the model.
  task automatic step(input logic v, input logic [7:0] p, input logic w,
                      input logic [7:0] d, input logic a, input string tag);
    logic [7:0] lv, pend, thr;
    logic       flag;
    @(negedge clk);
    nv = v; np = p; cw = w; cd = d; ar = a;
    #1;
    lv = lead(m_pend);
    chk({tag, " irq"}, {15'd0, irq}, {15'd0, m_flag});
    if (a) chk({tag, " accept"}, adata, {m_flag, 7'd0, m_flag ? lv : m_thr});
    pend = m_pend; thr = m_thr; flag = m_flag;
    if (a && m_flag) begin
      thr  = lv;
      pend = pend & ~(8'h80 >> lv);
      flag = 1'b0;
    end else if (w) begin
      thr = d;
    end
    if (v && p <= 8'd7) pend = pend | (8'h80 >> p);
    if (lead(pend) < thr) flag = 1'b1;
    m_pend = pend; m_thr = thr; m_flag = flag;
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    do_reset();
    // R1 reset state
    idle("R1");
    step(0, 0, 0, 0, 1, "R1");
    chk("R1 const", adata, 16'h00FF);

    // R2 out-of-range ignored, then priority 3 raises
    step(1, 8'd9, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 1, "R2");
    chk("R2 const", adata, 16'h00FF);
    step(1, 8'd3, 0, 0, 0, "R2");
    idle("R4");
    step(0, 0, 0, 0, 1, "R7");
    chk("R7 const", adata, 16'h8003);
    idle("R6");

    // R9 duplicates collapse
    do_reset();
    step(1, 8'd4, 0, 0, 0, "R9");
    step(1, 8'd4, 0, 0, 0, "R9");
    step(1, 8'd4, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 1, "R9");
    chk("R9 const", adata, 16'h8004);
    step(0, 0, 0, 0, 1, "R8");
    chk("R8 const", adata, 16'h0004);
    step(0, 0, 0, 0, 1, "R8");

    // R3 most favoured wins
    do_reset();
    step(1, 8'd6, 0, 0, 0, "R3");
    step(1, 8'd2, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 1, "R3");
    chk("R3 const", adata, 16'h8002);
    step(0, 0, 1, 8'hFF, 0, "R5");
    idle("R5");
    step(0, 0, 0, 0, 1, "R3");
    chk("R3 const2", adata, 16'h8006);

    // R4 equal does not raise, smaller does
    do_reset();
    step(0, 0, 1, 8'd5, 0, "R4");
    step(1, 8'd5, 0, 0, 0, "R4");
    idle("R4");
    chk("R4 eq", {15'd0, irq}, 16'd0);
    step(1, 8'd4, 0, 0, 0, "R4");
    idle("R4");

    // R5 threshold write raises
    do_reset();
    step(0, 0, 1, 8'd0, 0, "R5");
    step(1, 8'd3, 0, 0, 0, "R5");
    idle("R5");
    step(0, 0, 1, 8'd4, 0, "R5");
    idle("R5");
    chk("R5 const", {15'd0, irq}, 16'd1);

    // R10 notify merged after accept
    do_reset();
    step(1, 8'd3, 0, 0, 0, "R10");
    step(1, 8'd1, 0, 0, 1, "R10");
    chk("R10 ret", adata, 16'h8003);
    idle("R10");
    step(0, 0, 0, 0, 1, "R10");
    chk("R10 const", adata, 16'h8001);

    // R11 accept wins over threshold write
    do_reset();
    step(1, 8'd2, 0, 0, 0, "R11");
    step(0, 0, 1, 8'd7, 1, "R11");
    step(0, 0, 0, 0, 1, "R11");
    chk("R11 const", adata, 16'h0002);

    // R12 sticky flag
    do_reset();
    step(1, 8'd3, 0, 0, 0, "R12");
    step(0, 0, 1, 8'd0, 0, "R12");
    idle("R12");
    chk("R12 const", {15'd0, irq}, 16'd1);
    step(0, 0, 0, 0, 1, "R12");
    chk("R12 ret", adata, 16'h8003);

    // R4 sweep: every priority against a set of thresholds
    for (int p = 0; p < 10; p++) begin
      for (int c = 0; c < 10; c++) begin
        do_reset();
        step(0, 0, 1, (c == 9) ? 8'hFF : 8'(c), 0, "R4");
        step(1, 8'(p), 0, 0, 0, "R4");
        idle("R4");
        step(0, 0, 0, 0, 1, "R6");
        idle("R6");
      end
    end

    // Pseudo-random mix
    do_reset();
    lf = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] & lf[1], 8'(lf[7:4] % 10), lf[2] & lf[3] & lf[8],
           lf[9] ? 8'hFF : 8'(lf[12:10]), lf[13] & ~lf[14], "R7");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule